// File: doc/BRIEF.md
# Reloading down-count interval timer

A 16-bit programmable interval timer for a larger chip's peripheral set. A counter steps down by one on every count event. Its events come from one of four sources: every system clock, every eighth clock, every thirty-second clock, or every thirty-second pulse of a separate low-speed strobe input. When the counter is at zero and an event arrives, it reloads from a reload register and keeps counting. A one-cycle interrupt request marks each reload, so with a programmed value n the request repeats every n+1 events.

Software reaches the block through three write strobes: the count register, the mode register and the run bit. The read side always shows the live counter, the stored mode byte and the run state. A count write made while the timer is stopped, or after a start but before the first count event, sets both the counter and the reload register. Once the first event after a start has passed, a count write changes only the reload register. The counter then picks up that value at its next reload.

Top module: `rld_itimer`

## Requirements
- R1: After reset the counter reads 0, the mode byte reads 00h, the run bit reads 0 and the interrupt output is low.
- R2: While the timer runs in timer mode, each count event lowers the counter by exactly one. The read port always shows the live counter and never the reload value.
- R3: An event that finds the counter at 0 loads the reload value. The interrupt output is high for one clock, in the cycle in which the reloaded value first shows. With programmed value n, requests repeat every n+1 events.
- R4: Mode bits 7:6 pick the event source. 00 gives an event on every clock, 01 every 8 clocks, 10 every 32 clocks, and 11 every 32nd clock in which the slow strobe input is high.
- R5: Writing 1 to the run bit starts counting and writing 0 stops it. While the timer is stopped, the counter holds its value.
- R6: A count write while the timer is stopped loads both the counter and the reload register.
- R7: After a 0-to-1 run transition and before the first count event, a count write loads both the counter and the reload register. Every new start re-arms this window.
- R8: After the first count event following a start, a count write changes only the reload register and leaves the counter unchanged.
- R9: When a reload-only count write falls in the same cycle as an underflow, the counter takes the newly written value and the interrupt still fires.
- R10: When mode bits 1:0 are not 00, no counting takes place and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count register write data |
| cnt_rdata | output | 16 | Live counter value |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode byte; bits 1:0 operation mode, bits 7:6 source select |
| mode_rdata | output | 8 | Stored mode byte |
| run_wr | input | 1 | Run bit write strobe |
| run_wdata | input | 1 | Run bit value, 1 start, 0 stop |
| run_rdata | output | 1 | Current run state |
| slow_stb | input | 1 | Low-speed source strobe, one clock wide |
| irq | output | 1 | One-cycle interrupt request on each underflow |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is a count write and an underflow. The bench provokes it by holding the low-speed source under its own control. It brings the counter to zero, then raises the 32nd slow pulse together with the write strobe, and expects the written value on the read port with the interrupt high. The second pair is a count write and the first event after a start, or no event at all. Writes placed just before and just after a single delivered event are judged by whether the read value moves.

// File: rtl/rit_pkg.sv
package rit_pkg;
   typedef enum logic [1:0] {
      SRC_BASE  = 2'b00,
      SRC_DIV_A = 2'b01,
      SRC_DIV_B = 2'b10,
      SRC_SLOW  = 2'b11
   } src_e;

   localparam logic [1:0] OPMODE_TIMER = 2'b00;
   localparam int         OPMODE_LSB   = 0;
   localparam int         SRC_LSB      = 6;
   localparam int         MODE_W       = 8;

   function automatic src_e src_of(input logic [MODE_W-1:0] mode);
      return src_e'(mode[SRC_LSB +: 2]);
   endfunction

   function automatic logic timer_mode(input logic [MODE_W-1:0] mode);
      return mode[OPMODE_LSB +: 2] == OPMODE_TIMER;
   endfunction
endpackage

// File: rtl/rit_div.sv
module rit_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic stb
);
   localparam int W = $clog2(DIV);
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] cnt_q;

   initial begin
      assert (DIV >= 2 && (DIV & (DIV - 1)) == 0)
         else $error("rit_div: DIV must be a power of two of at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (en) cnt_q <= cnt_q + W'(1);
   end

   assign stb = en && (cnt_q == LAST);
endmodule

// File: rtl/rit_core.sv
module rit_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             run_rise,
   input  logic             run_q,
   input  logic             ev,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count,
   output logic             first_seen,
   output logic             irq
);
   logic [CNT_W-1:0] count_q, reload_q, reload_d, count_d;
   logic             seen_q, irq_q, step, uflow, direct_wr;

   assign step      = run_en && ev;
   assign uflow     = step && (count_q == '0);
   assign direct_wr = wr && (!run_q || !seen_q);
   assign reload_d  = wr ? wdata : reload_q;

   always_comb begin
      count_d = count_q;
      if (direct_wr)  count_d = wdata;
      else if (uflow) count_d = reload_d;
      else if (step)  count_d = count_q - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
         seen_q   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         count_q  <= count_d;
         reload_q <= reload_d;
         irq_q    <= uflow;
         if (run_rise)  seen_q <= 1'b0;
         else if (step) seen_q <= 1'b1;
      end
   end

   assign count      = count_q;
   assign first_seen = seen_q;
   assign irq        = irq_q;
endmodule

// File: rtl/rld_itimer.sv
module rld_itimer #(
   parameter int CNT_W  = 16,
   parameter int DIV_A  = 8,
   parameter int DIV_B  = 32,
   parameter int DIV_SL = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_rdata,
   input  logic             mode_wr,
   input  logic [7:0]       mode_wdata,
   output logic [7:0]       mode_rdata,
   input  logic             run_wr,
   input  logic             run_wdata,
   output logic             run_rdata,
   input  logic             slow_stb,
   output logic             irq
);
   import rit_pkg::*;

   localparam int NTAP = 2;
   localparam int TAP_DIV [NTAP] = '{DIV_A, DIV_B};

   logic [MODE_W-1:0] mode_q;
   logic              run_q, run_rise, run_en, ev, first_seen, slow_ev;
   logic [NTAP-1:0]   tap_stb;

   initial begin
      assert (CNT_W >= 2) else $error("rld_itimer: CNT_W too small");
      assert (DIV_A < DIV_B) else $error("rld_itimer: taps must ascend");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         run_q  <= 1'b0;
      end else begin
         if (mode_wr) mode_q <= mode_wdata;
         if (run_wr)  run_q  <= run_wdata;
      end
   end

   assign run_rise = run_wr && run_wdata && !run_q;
   assign run_en   = run_q && timer_mode(mode_q);

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      rit_div #(.DIV(TAP_DIV[t])) u_div (
         .clk(clk), .rst_n(rst_n), .en(1'b1), .stb(tap_stb[t])
      );
   end

   rit_div #(.DIV(DIV_SL)) u_slow (
      .clk(clk), .rst_n(rst_n), .en(slow_stb), .stb(slow_ev)
   );

   always_comb begin
      unique case (src_of(mode_q))
         SRC_BASE:  ev = 1'b1;
         SRC_DIV_A: ev = tap_stb[0];
         SRC_DIV_B: ev = tap_stb[1];
         SRC_SLOW:  ev = slow_ev;
         default:   ev = 1'b0;
      endcase
   end

   rit_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .run_rise(run_rise),
      .run_q(run_q), .ev(ev), .wr(cnt_wr), .wdata(cnt_wdata),
      .count(cnt_rdata), .first_seen(first_seen), .irq(irq)
   );

   assign mode_rdata = mode_q;
   assign run_rdata  = run_q;
endmodule

// File: rtl/rit_check.sv
module rit_check #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic [CNT_W-1:0] cnt_rdata,
   input logic             run_rdata,
   input logic [7:0]       mode_rdata,
   input logic             irq,
   input logic             ev,
   input logic             first_seen
);
   p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && run_rdata && mode_rdata[1:0] == 2'b00 && cnt_rdata != '0 && !cnt_wr)
      |=> cnt_rdata == $past(cnt_rdata) - CNT_W'(1));

   p_irq_from_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cnt_rdata) == '0 && $past(run_rdata));

   p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_rdata && !cnt_wr) |=> cnt_rdata == $past(cnt_rdata));

   p_load_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !run_rdata) |=> cnt_rdata == $past(cnt_wdata));

   p_reload_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && run_rdata && first_seen && !ev) |=> cnt_rdata == $past(cnt_rdata));

   p_no_irq_other_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rdata[1:0] != 2'b00) |=> !irq);
endmodule

bind rld_itimer rit_check #(.CNT_W(CNT_W)) u_rit_check (.*);

// File: tb/test_rld_itimer.sv
module test_rld_itimer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_wr = 1'b0, mode_wr = 1'b0, run_wr = 1'b0, run_wdata = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic [7:0]  mode_wdata = '0;
   logic        slow_stb = 1'b0;
   logic [15:0] cnt_rdata;
   logic [7:0]  mode_rdata;
   logic        run_rdata, irq;

   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rld_itimer i_rld_itimer (.*);

   // {source select, programmed value, expected underflow period in clocks}
   localparam logic [49:0] TV [5] = '{
      {2'd0, 16'd0, 32'd1},
      {2'd0, 16'd3, 32'd4},
      {2'd0, 16'd6, 32'd7},
      {2'd1, 16'd2, 32'd24},
      {2'd2, 16'd1, 32'd64}
   };

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic wr_cnt(input logic [15:0] v);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic wr_mode(input logic [7:0] v);
      @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic wr_run(input logic v);
      @(negedge clk); run_wr = 1'b1; run_wdata = v;
      @(negedge clk); run_wr = 1'b0;
   endtask

   task automatic pulses(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk); slow_stb = 1'b1;
         @(negedge clk); slow_stb = 1'b0;
      end
   endtask

   task automatic wait_irq(output bit ok);
      ok = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (irq) begin ok = 1; break; end
      end
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ok;
      int per, seen, snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count", cnt_rdata, 0);
      check("R1 mode", mode_rdata, 0);
      check("R1 run", run_rdata, 0);
      check("R1 irq", irq, 0);

      // R3 / R4: underflow period per source and value
      foreach (TV[k]) begin
         wr_run(1'b0);
         wr_mode({TV[k][49:48], 6'b0});
         wr_cnt(TV[k][47:32]);
         wr_run(1'b1);
         wait_irq(ok);
         per = 0;
         if (ok) begin
            for (int i = 0; i < 4000; i++) begin
               @(negedge clk); per++;
               if (irq) break;
            end
         end
         check("R3 R4 period", per, int'(TV[k][31:0]));
      end

      // R5 stop/start, R2 exact decrement
      wr_mode(8'h00);
      wr_run(1'b0);
      snap = cnt_rdata;
      repeat (10) @(negedge clk);
      check("R5 hold while stopped", cnt_rdata, snap);
      wr_cnt(16'd100);
      check("R6 stopped write", cnt_rdata, 100);
      wr_run(1'b1);
      check("R5 start no early step", cnt_rdata, 100);
      repeat (5) @(negedge clk);
      check("R2 five steps", cnt_rdata, 95);

      // R10 non-timer operation mode
      wr_mode(8'h01);
      @(negedge clk);
      snap = cnt_rdata;
      seen = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (irq) seen++;
      end
      check("R10 count frozen", cnt_rdata, snap);
      check("R10 no irq", seen, 0);

      // slow source, write steering
      wr_run(1'b0);
      wr_mode(8'hC0);
      wr_cnt(16'd10);
      check("R6 stopped write", cnt_rdata, 10);
      wr_run(1'b1);
      wr_cnt(16'd7);
      check("R7 before first event", cnt_rdata, 7);
      pulses(31);
      check("R4 31 slow pulses no event", cnt_rdata, 7);
      pulses(1);
      check("R2 one slow event", cnt_rdata, 6);
      wr_cnt(16'd20);
      check("R8 reload only", cnt_rdata, 6);
      pulses(6 * 32);
      check("R2 reach zero", cnt_rdata, 0);
      pulses(32);
      check("R3 reload new value", cnt_rdata, 20);
      check("R3 irq with reload", irq, 1);
      @(negedge clk);
      check("R3 irq one cycle", irq, 0);

      // R9 write coinciding with underflow
      wr_run(1'b0);
      wr_cnt(16'd0);
      wr_run(1'b1);
      pulses(32);
      check("R9 setup at zero", cnt_rdata, 0);
      pulses(31);
      @(negedge clk); slow_stb = 1'b1; cnt_wr = 1'b1; cnt_wdata = 16'd9;
      @(negedge clk); slow_stb = 1'b0; cnt_wr = 1'b0;
      check("R9 count takes written value", cnt_rdata, 9);
      check("R9 irq", irq, 1);

      // R7 restart re-arms the load-both window
      wr_run(1'b0);
      wr_run(1'b1);
      wr_cnt(16'd3);
      check("R7 after restart", cnt_rdata, 3);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule